// File: doc/BRIEF.md
# Pipelined Converter Code Aligner and Corrector

This block is the digital back end of a four-stage pipelined analog-to-digital converter. Each of the four sub-converters hands over a 4-bit code for every sample. The first three stages resolve three effective bits plus one overlap bit, and the last stage is a plain 4-bit flash. Alternate stages work on opposite clock phases, so the codes for one sample do not arrive together. The later pair of stages comes one cycle after the earlier pair. Per-stage delay lines realign the codes, and a correction adder then overlaps them into a single 12-bit offset-binary word. The result passes through two output registers before it reaches the bus.

In the correction, each stage code is weighted by its bit position. Every stage carries an intentional half-step shift, and the sum of these shifts is removed as one constant. This lets a decision error of one step in an early stage be absorbed by the following stage. The corrected value is clamped to the 12-bit range, so it never wraps. A valid flag marks the words that belong to samples taken after reset.

Top module: `pipe_adc_corrector`

## Requirements
- R1: With stage codes B1 (bits 15:12 of `stage_codes`), B2 (11:8), B3 (7:4) and B4 (3:0), each unsigned, the output word is B1·512 + B2·64 + B3·8 + B4 − 2340 whenever that value lies in 0..4095.
- R2: When that weighted value exceeds 4095, the output word is 4095 (all ones), never a wrapped value.
- R3: When that weighted value is below 0, the output word is 0.
- R4: A sample's B1 and B2 are presented on the same cycle, and its B3 and B4 are presented one cycle later. The block combines the four codes of the same sample, so a stream whose codes change on every cycle still reconstructs each value.
- R5: The word for a sample whose B1 is captured at clock edge n is on `sample_word` just after edge n+3. A new word follows on every later edge.
- R6: After reset is released, `word_valid` stays low for the first three edges, rises after the fourth edge and then stays high until the next reset.
- R7: A synchronous active-high reset clears `sample_word` to 0 and drops `word_valid` on the next edge, even in the middle of a stream.
- R8: A one-step error in stage k (k = 1..3) that the next stage compensates with a shift of eight codes in the opposite direction yields the same word as the error-free codes. Ideal codes are each digit plus 4, so midscale 2048 comes out as 1000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stage_codes | input | 16 | Four stage codes: stage 1 in 15:12 through stage 4 in 3:0 |
| sample_word | output | 12 | Corrected offset-binary result |
| word_valid | output | 1 | High when `sample_word` holds a post-reset sample |

## Verification
Error-free codes for the extremes, midscale and irregular bit patterns exercise the plain weighting and the removal of the offset. Codes carrying compensated one-step errors at each of the three redundant stages show that the correction truly overlaps the stages rather than concatenating them. Code sets just past either end of the range, together with all-ones and all-zeros, separate clamping from wrap-around. A stream in which every sample differs from its neighbours, checked on exact edges, would expose a misaligned delay line or a wrong latency.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // Whole-cycle lag of stage k (zero based): alternate stages work on
  // opposite half cycles, so each pair of stages adds one cycle.
  function automatic int stage_lag(input int k);
    return k / 2;
  endfunction

  // Sum of every stage's half-step shift, in output LSBs.
  function automatic int corr_offset(input int nstg, input int eff, input int cw);
    int s;
    s = 0;
    for (int k = 0; k < nstg; k++) s += (1 << (eff * k));
    return (1 << (cw - 2)) * s;
  endfunction

endpackage

// File: rtl/adc_skew_line.sv
module adc_skew_line #(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign dout = sr[DEPTH-1];

endmodule

// File: rtl/adc_code_merge.sv
module adc_code_merge #(
  parameter int NSTG = 4,
  parameter int CW   = 4,
  parameter int EFF  = 3
) (
  input  logic [NSTG*CW-1:0]  codes,
  output logic [NSTG*EFF-1:0] word
);

  localparam int OUTW = NSTG * EFF;
  localparam int SW   = OUTW + CW + 1;
  localparam logic signed [SW-1:0] OFFS_S =
    SW'(adc_corr_pkg::corr_offset(NSTG, EFF, CW));
  localparam logic signed [SW-1:0] MAXS = SW'((1 << OUTW) - 1);

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] term;

  always_comb begin
    acc  = -OFFS_S;
    term = '0;
    for (int k = 0; k < NSTG; k++) begin
      term         = '0;
      term[CW-1:0] = codes[k*CW +: CW];
      acc          = acc + (term <<< (EFF * k));
    end
    if (acc < 0)         word = '0;
    else if (acc > MAXS) word = '1;
    else                 word = acc[OUTW-1:0];
  end

endmodule

// File: rtl/adc_out_dbuf.sv
module adc_out_dbuf #(
  parameter int W    = 12,
  parameter int VLEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] mid,
  output logic [W-1:0] q,
  output logic         vld
);

  logic [VLEN-1:0] vsr;
  logic [1:0]      seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid  <= '0;
      q    <= '0;
      vsr  <= '0;
      seen <= '0;
    end else begin
      mid  <= d;
      q    <= mid;
      vsr  <= {vsr[VLEN-2:0], 1'b1};
      if (seen != 2'd2) seen <= seen + 2'd1;
    end
  end

  assign vld = vsr[VLEN-1];

  // R5: two register stages between the merged word and the bus
  a_r5_two_stage: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd2) |=> (q == $past(d, 2)));

  // R6: once valid, stays valid until reset
  a_r6_valid_holds: assert property (@(posedge clk) disable iff (rst)
    vld |=> vld);

  // R7: reset clears both buffers and the flag
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0 && mid == '0 && !vld));

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NSTG = 4,
  parameter int CW   = 4,
  parameter int EFF  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSTG*CW-1:0]   stage_codes,
  output logic [NSTG*EFF-1:0]  sample_word,
  output logic                 word_valid
);

  localparam int OUTW   = NSTG * EFF;
  localparam int CODEW  = NSTG * CW;
  localparam int MAXLAG = adc_corr_pkg::stage_lag(NSTG - 1);
  localparam int VLEN   = MAXLAG + 3;

  logic [CODEW-1:0] aligned;
  logic [OUTW-1:0]  merged;
  logic [OUTW-1:0]  mid_word;

  // Stage s (0 = first) sits at the top of the bus; early stages wait longer.
  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam int LSB = (NSTG - 1 - s) * CW;
    adc_skew_line #(
      .W     (CW),
      .DEPTH (MAXLAG - adc_corr_pkg::stage_lag(s) + 1)
    ) u_line (
      .clk  (clk),
      .rst  (rst),
      .din  (stage_codes[LSB +: CW]),
      .dout (aligned[LSB +: CW])
    );
  end

  adc_code_merge #(
    .NSTG (NSTG),
    .CW   (CW),
    .EFF  (EFF)
  ) u_merge (
    .codes (aligned),
    .word  (merged)
  );

  adc_out_dbuf #(
    .W    (OUTW),
    .VLEN (VLEN)
  ) u_obuf (
    .clk (clk),
    .rst (rst),
    .d   (merged),
    .mid (mid_word),
    .q   (sample_word),
    .vld (word_valid)
  );

  // R2: all-ones aligned codes overflow and must clamp high
  a_r2_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (aligned == '1) |=> (mid_word == '1));

  // R3: all-zero aligned codes underflow and must clamp low
  a_r3_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (aligned == '0) |=> (mid_word == '0));

endmodule

// File: tb/sim_pipe_adc_corrector.sv
`timescale 1ns/1ps
module sim_pipe_adc_corrector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] stage_codes = '0;
  logic [11:0] sample_word;
  logic        word_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] cb   [0:63];
  int          expv [0:63];
  int          nsamp;

  always #2 clk = ~clk;

  pipe_adc_corrector u0 (
    .clk         (clk),
    .rst         (rst),
    .stage_codes (stage_codes),
    .sample_word (sample_word),
    .word_valid  (word_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference from R1..R3
  function automatic int ref_word(input logic [15:0] c);
    int v;
    v = int'(c[15:12]) * 512 + int'(c[11:8]) * 64 + int'(c[7:4]) * 8 + int'(c[3:0]) - 2340;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  // Ideal codes (digit+4); err_stg 1..3 adds a compensated one-step error (R8)
  function automatic logic [15:0] enc(input int v, input int err_stg);
    int b [4];
    int s;
    b[0] = ((v >> 9) & 7) + 4;
    b[1] = ((v >> 6) & 7) + 4;
    b[2] = ((v >> 3) & 7) + 4;
    b[3] = (v & 7) + 4;
    if (err_stg >= 1 && err_stg <= 3) begin
      s = (b[err_stg] >= 8) ? 1 : -1;
      b[err_stg-1] = b[err_stg-1] + s;
      b[err_stg]   = b[err_stg] - 8 * s;
    end
    return {4'(b[0]), 4'(b[1]), 4'(b[2]), 4'(b[3])};
  endfunction

  // Applies reset, streams cb[] with B3/B4 one cycle behind B1/B2 (R4),
  // checks each word exactly three edges after its B1 capture (R5).
  task automatic run_stream(input string req);
    logic [7:0] hi;
    logic [7:0] lo;
    rst = 1'b1;
    stage_codes = '0;
    repeat (2) @(negedge clk);
    chk(sample_word == 12'd0, "R7 reset word", int'(sample_word), 0);
    chk(word_valid == 1'b0, "R7 reset valid", int'(word_valid), 0);
    rst = 1'b0;
    for (int k = 0; k < nsamp + 4; k++) begin
      hi = (k < nsamp) ? cb[k][15:8] : 8'h00;
      lo = (k >= 1 && k - 1 < nsamp) ? cb[k-1][7:0] : 8'h00;
      stage_codes = {hi, lo};
      if (k < 4) begin
        chk(word_valid == 1'b0, "R6 valid low while filling", int'(word_valid), 0);
      end else begin
        chk(word_valid == 1'b1, "R6 valid high", int'(word_valid), 1);
        chk(int'(sample_word) == expv[k-4], req, int'(sample_word), expv[k-4]);
      end
      @(negedge clk);
    end
  endtask

  task automatic test_ideal();
    int vals [8] = '{0, 4095, 2048, 2047, 1, 2652, 1443, 3000};
    nsamp = 8;
    for (int i = 0; i < 8; i++) begin
      cb[i] = enc(vals[i], 0);
      expv[i] = vals[i];
    end
    run_stream("R1 ideal codes");
    chk(enc(2048, 0) == 16'h8444, "R8 midscale codes", int'(enc(2048, 0)), 16'h8444);
  endtask

  task automatic test_overlap();
    int vals [9] = '{100, 2048, 3900, 777, 1234, 4000, 63, 2600, 512};
    nsamp = 9;
    for (int i = 0; i < 9; i++) begin
      cb[i] = enc(vals[i], (i % 3) + 1);
      expv[i] = vals[i];
    end
    run_stream("R8 corrected overlap error");
  endtask

  task automatic test_saturate();
    logic [15:0] c [6] = '{16'hFFFF, 16'h0000, 16'hBBBC, 16'h3333, 16'h4443, 16'hBBBB};
    nsamp = 6;
    for (int i = 0; i < 6; i++) begin
      cb[i] = c[i];
      expv[i] = ref_word(c[i]);
    end
    chk(expv[0] == 4095 && expv[2] == 4095, "R2 model high", expv[2], 4095);
    chk(expv[1] == 0 && expv[4] == 0, "R3 model low", expv[4], 0);
    run_stream("R2 R3 clamp");
  endtask

  task automatic test_align();
    nsamp = 32;
    for (int i = 0; i < 32; i++) begin
      expv[i] = (i * 1171 + 37) % 4096;
      cb[i] = enc(expv[i], 0);
    end
    run_stream("R4 R5 aligned stream");
  endtask

  task automatic test_mid_reset();
    nsamp = 6;
    for (int i = 0; i < 6; i++) begin
      expv[i] = 3000 + i * 91;
      cb[i] = enc(expv[i], 0);
    end
    run_stream("R5 before reset");
    stage_codes = enc(4000, 0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sample_word == 12'd0, "R7 mid-stream reset word", int'(sample_word), 0);
    chk(word_valid == 1'b0, "R7 mid-stream reset valid", int'(word_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(word_valid == 1'b0, "R6 refill valid low", int'(word_valid), 0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_ideal();
    test_overlap();
    test_saturate();
    test_align();
    test_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule